// File: doc/BRIEF.md
# ISA I/O Window Decoder and Interrupt Glue for a USB Device Controller

This block connects an 8-bit ISA-style I/O bus to a USB device controller that has one data port and one command port. It claims a window of eight consecutive I/O addresses. Address bits 9..3 are compared with a seven-position DIP switch, and bits 2..0 pick the location within the window. Besides the two controller ports, the window holds a read-only status port and a write-only control port. The status port returns four key inputs, the VBUS sense, the controller's suspend pin and its interrupt pin. The control port drives four LEDs, a suspend-override that pulls the controller's suspend pin low, and an interrupt enable. The enable turns the controller's active-low level interrupt into an ISA interrupt line that rises when the enable is set.

The design runs on a single clock. A bus-cycle state machine samples the decoded address and the active-low command strobes. On the first clock edge that sees a valid access, it moves from `ST_IDLE` to one of six access states. In the cycles that follow, the outputs are driven from that state.

The states are:
- `ST_RD_DATA`: controller data read.
- `ST_RD_PORT`: status port read.
- `ST_WR_DATA`: controller data write.
- `ST_WR_CMD`: controller command write.
- `ST_WR_PORT`: control port load.
- `ST_HOLD`: a valid strobe at a location that takes no action for that direction.

The transitions are:
- IDLE→access: the address matches and exactly one strobe is low.
- access→access: a strobe is still low, so the machine stays in the same state.
- access→IDLE: both strobes are high.

The address is not examined again until the machine returns to `ST_IDLE`.

Top module: `isa_usb_glue`

## Requirements
- R1: `brd_sel_n` is low, combinationally, exactly when `isa_addr[9:3]` equals `base_sw`. A switch that is ON reads 0, so the setting 7'b1101101 selects base 0x368.
- R2: A read at offset 0 works as follows. From the first clock edge that sees `isa_ior_n` low until the first edge that sees both strobes high:
  - `ctl_rd_n` is low and `ctl_a0` is 0;
  - `isa_doe` is 1;
  - `isa_dout` equals `ctl_rdata`.
- R3: A write at offset 0 drives `ctl_wr_n` low with `ctl_a0`=0. A write at offset 1 drives `ctl_wr_n` low with `ctl_a0`=1. Each strobe follows the write strobe with one cycle of delay.
- R4: A read at offset 2 drives `isa_dout` with the following fields:
  - bit 7 is `ctl_int_n`;
  - bit 6 is `ctl_susp_pin`;
  - bit 5 is `vbus_ok`;
  - bit 4 is 0;
  - bits 3..0 are `keys_n`, where a pressed key reads 0.
- R5: A write at offset 3 loads the control port. Bits 3..0 appear on `leds`, where 1 lights the LED. Bits 4 and 5 have no effect on any output.
- R6: `susp_force` equals bit 6 of the last control-port write. When it is 1, the controller's suspend pin is forced low.
- R7: `isa_irq` is high exactly when control bit 7 is 1 and `ctl_int_n` is 0. Clearing bit 7 and setting it again while `ctl_int_n` stays low produces a fresh rising edge.
- R8: The following accesses drive no data, pulse no controller strobe and leave the control port unchanged:
  - reads at offsets 1, 3 and 4–7;
  - writes at offsets 2 and 4–7.
- R9: While `rst` is high, and after it falls, the following hold:
  - the control port reads as all zeros: LEDs off, no suspend override, interrupt disabled;
  - both controller strobes are high;
  - `isa_doe` is 0.
- R10: A strobe at an address outside the window, or with both strobes low together, starts no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| isa_addr | input | 10 | I/O address A9..A0 |
| isa_ior_n | input | 1 | I/O read strobe, active low |
| isa_iow_n | input | 1 | I/O write strobe, active low |
| base_sw | input | 7 | Base switch levels for A9..A3 (ON = 0) |
| isa_din | input | 8 | Data from the bus during writes |
| isa_dout | output | 8 | Data to the bus during reads |
| isa_doe | output | 1 | Bus data output enable |
| brd_sel_n | output | 1 | Window match, active low |
| ctl_rd_n | output | 1 | Controller read strobe, active low |
| ctl_wr_n | output | 1 | Controller write strobe, active low |
| ctl_a0 | output | 1 | Controller port select: 0 data, 1 command |
| ctl_rdata | input | 8 | Read data from the controller |
| ctl_int_n | input | 1 | Controller interrupt, active low level |
| ctl_susp_pin | input | 1 | Controller suspend pin state |
| vbus_ok | input | 1 | USB VBUS present |
| keys_n | input | 4 | Key inputs, 0 when pressed |
| leds | output | 4 | LED drives, 1 lights |
| susp_force | output | 1 | Pull the controller suspend pin low |
| isa_irq | output | 1 | ISA interrupt, rising edge |

## Verification
The bench targets the following corner cases.

Address decode:
- It sweeps all 128 values of A9..A3 against two switch settings. A comparator that inverted the switch levels, or used a wrong bit, would flag the wrong window.

Status and control ports:
- It sweeps every combination of key, VBUS, suspend and interrupt level through the status port. A swapped or shifted field shows up as a wrong read value.
- It writes all 256 control values and checks the LEDs, the suspend override and the gated interrupt. This catches a missing gate or a bit taken from the wrong position.

Accesses that must do nothing:
- Reserved offsets, reads at write-only offsets, collisions of both strobes and out-of-window addresses must leave the bus undriven and the control port untouched. A decoder that let any of them through would change the LEDs or assert `isa_doe`.

Interrupt gate:
- The bench toggles the enable while the interrupt stays low, to catch a design that latched the level instead of gating it.

// File: rtl/glue_pkg.sv
package glue_pkg;
    localparam int ADDR_W = 10;
    localparam int OFF_W  = 3;
    localparam int SEL_W  = ADDR_W - OFF_W;
    localparam int DATA_W = 8;
    localparam int KEY_N  = 4;

    localparam logic [OFF_W-1:0] OFF_CTL_DATA = 3'd0;
    localparam logic [OFF_W-1:0] OFF_CTL_CMD  = 3'd1;
    localparam logic [OFF_W-1:0] OFF_STATUS   = 3'd2;
    localparam logic [OFF_W-1:0] OFF_CONTROL  = 3'd3;

    localparam int BIT_SUSP = 6;
    localparam int BIT_IEN  = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_DATA,
        ST_RD_PORT,
        ST_WR_DATA,
        ST_WR_CMD,
        ST_WR_PORT,
        ST_HOLD
    } bus_state_t;
endpackage

// File: rtl/glue_addr_dec.sv
module glue_addr_dec
    import glue_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int OW = OFF_W
) (
    input  logic [AW-1:0]    addr,
    input  logic [AW-OW-1:0] sw,
    output logic             hit,
    output logic [OW-1:0]    offset
);
    always_comb begin
        hit    = (addr[AW-1:OW] == sw);
        offset = addr[OW-1:0];
    end
endmodule

// File: rtl/glue_bus_fsm.sv
module glue_bus_fsm
    import glue_pkg::*;
#(
    parameter int OW = OFF_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hit,
    input  logic [OW-1:0] offset,
    input  logic          ior_n,
    input  logic          iow_n,
    output bus_state_t    state,
    output logic          ctl_rd_n,
    output logic          ctl_wr_n,
    output logic          ctl_a0,
    output logic          rd_data,
    output logic          rd_port,
    output logic          ld_port
);
    bus_state_t nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (hit && !ior_n && iow_n) begin
                    if (offset == OFF_CTL_DATA)    nxt = ST_RD_DATA;
                    else if (offset == OFF_STATUS) nxt = ST_RD_PORT;
                    else                           nxt = ST_HOLD;
                end else if (hit && ior_n && !iow_n) begin
                    if (offset == OFF_CTL_DATA)     nxt = ST_WR_DATA;
                    else if (offset == OFF_CTL_CMD) nxt = ST_WR_CMD;
                    else if (offset == OFF_CONTROL) nxt = ST_WR_PORT;
                    else                            nxt = ST_HOLD;
                end
            end
            ST_RD_DATA, ST_RD_PORT, ST_WR_DATA, ST_WR_CMD, ST_WR_PORT, ST_HOLD: begin
                if (ior_n && iow_n) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        ctl_rd_n = 1'b1;
        ctl_wr_n = 1'b1;
        ctl_a0   = 1'b0;
        rd_data  = 1'b0;
        rd_port  = 1'b0;
        ld_port  = 1'b0;
        unique case (state)
            ST_RD_DATA: begin ctl_rd_n = 1'b0; rd_data = 1'b1; end
            ST_RD_PORT: rd_port = 1'b1;
            ST_WR_DATA: ctl_wr_n = 1'b0;
            ST_WR_CMD:  begin ctl_wr_n = 1'b0; ctl_a0 = 1'b1; end
            ST_WR_PORT: ld_port = 1'b1;
            ST_IDLE, ST_HOLD: ;
            default: ;
        endcase
    end

    AST_RD_FOLLOWS_IOR: assert property (@(posedge clk) disable iff (rst)
        !ctl_rd_n |-> $past(!ior_n) || $past(!ctl_rd_n)); // R2
    AST_WR_FOLLOWS_IOW: assert property (@(posedge clk) disable iff (rst)
        $rose(!ctl_wr_n) |-> $past(!iow_n)); // R3
    AST_ONE_CTL_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(!ctl_rd_n && !ctl_wr_n)); // R10
    AST_STRB_RELEASE: assert property (@(posedge clk) disable iff (rst)
        ($past(ior_n) && $past(iow_n)) |-> (ctl_rd_n && ctl_wr_n && !ld_port)); // R8
endmodule

// File: rtl/glue_port_regs.sv
module glue_port_regs
    import glue_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int KN = KEY_N
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_port,
    input  logic [DW-1:0] din,
    input  logic          int_n,
    output logic [KN-1:0] leds,
    output logic          susp_force,
    output logic          irq
);
    logic [KN-1:0] led_q;
    logic          susp_q;
    logic          ien_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            led_q  <= '0;
            susp_q <= 1'b0;
            ien_q  <= 1'b0;
        end else if (ld_port) begin
            led_q  <= din[KN-1:0];
            susp_q <= din[BIT_SUSP];
            ien_q  <= din[BIT_IEN];
        end
    end

    always_comb begin
        leds       = led_q;
        susp_force = susp_q;
        irq        = ien_q & ~int_n;
    end

    AST_PORT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !$past(ld_port) |-> $stable(led_q) && $stable(susp_q) && $stable(ien_q)); // R5
    AST_IRQ_NEEDS_INT: assert property (@(posedge clk) disable iff (rst)
        irq |-> !int_n); // R7
endmodule

// File: rtl/isa_usb_glue.sv
module isa_usb_glue
    import glue_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int KN = KEY_N
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    isa_addr,
    input  logic             isa_ior_n,
    input  logic             isa_iow_n,
    input  logic [AW-OFF_W-1:0] base_sw,
    input  logic [DW-1:0]    isa_din,
    output logic [DW-1:0]    isa_dout,
    output logic             isa_doe,
    output logic             brd_sel_n,
    output logic             ctl_rd_n,
    output logic             ctl_wr_n,
    output logic             ctl_a0,
    input  logic [DW-1:0]    ctl_rdata,
    input  logic             ctl_int_n,
    input  logic             ctl_susp_pin,
    input  logic             vbus_ok,
    input  logic [KN-1:0]    keys_n,
    output logic [KN-1:0]    leds,
    output logic             susp_force,
    output logic             isa_irq
);
    localparam int PAD_W = DW - KN - 3;

    logic             hit;
    logic [OFF_W-1:0] offset;
    bus_state_t       state;
    logic             rd_data, rd_port, ld_port;
    logic [DW-1:0]    status_word;

    glue_addr_dec #(.AW(AW), .OW(OFF_W)) u_dec (
        .addr(isa_addr), .sw(base_sw), .hit(hit), .offset(offset)
    );

    glue_bus_fsm #(.OW(OFF_W)) u_fsm (
        .clk(clk), .rst(rst), .hit(hit), .offset(offset),
        .ior_n(isa_ior_n), .iow_n(isa_iow_n), .state(state),
        .ctl_rd_n(ctl_rd_n), .ctl_wr_n(ctl_wr_n), .ctl_a0(ctl_a0),
        .rd_data(rd_data), .rd_port(rd_port), .ld_port(ld_port)
    );

    glue_port_regs #(.DW(DW), .KN(KN)) u_regs (
        .clk(clk), .rst(rst), .ld_port(ld_port), .din(isa_din),
        .int_n(ctl_int_n), .leds(leds), .susp_force(susp_force), .irq(isa_irq)
    );

    always_comb begin
        status_word = {ctl_int_n, ctl_susp_pin, vbus_ok, {PAD_W{1'b0}}, keys_n};
        brd_sel_n   = ~hit;
        isa_doe     = rd_data | rd_port;
        isa_dout    = rd_data ? ctl_rdata : (rd_port ? status_word : '0);
    end

    AST_OE_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
        isa_doe |-> (state == ST_RD_DATA || state == ST_RD_PORT) && $past(!isa_ior_n)); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (!isa_doe && ctl_rd_n && ctl_wr_n)); // R9
endmodule

// File: tb/isa_usb_glue_tb.sv
module isa_usb_glue_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] isa_addr = '0;
    logic       isa_ior_n = 1'b1, isa_iow_n = 1'b1;
    logic [6:0] base_sw = 7'b1101101;
    logic [7:0] isa_din = '0;
    logic [7:0] isa_dout;
    logic       isa_doe, brd_sel_n, ctl_rd_n, ctl_wr_n, ctl_a0;
    logic [7:0] ctl_rdata = 8'h00;
    logic       ctl_int_n = 1'b1, ctl_susp_pin = 1'b0, vbus_ok = 1'b0;
    logic [3:0] keys_n = 4'hF;
    logic [3:0] leds;
    logic       susp_force, isa_irq;

    int n_chk = 0, n_fail = 0;
    logic       o_oe, o_rd, o_wr, o_a0;
    logic [7:0] o_dout;

    localparam logic [9:0] BASE = 10'h368;

    always #2 clk = ~clk;

    isa_usb_glue u_dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [9:0] a, input logic [7:0] d);
        @(negedge clk); isa_addr = a; isa_din = d; isa_iow_n = 1'b0;
        @(negedge clk); o_wr = ctl_wr_n; o_a0 = ctl_a0; o_oe = isa_doe; o_rd = ctl_rd_n;
        @(negedge clk); isa_iow_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_rd(input logic [9:0] a);
        @(negedge clk); isa_addr = a; isa_ior_n = 1'b0;
        @(negedge clk); o_oe = isa_doe; o_dout = isa_dout; o_rd = ctl_rd_n; o_wr = ctl_wr_n; o_a0 = ctl_a0;
        @(negedge clk); isa_ior_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #400000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 leds", leds, 0); check("R9 susp", susp_force, 0);
        check("R9 oe", isa_doe, 0); check("R9 strobes", {ctl_rd_n, ctl_wr_n}, 2'b11);
        rst = 1'b0;
        @(negedge clk);
        ctl_int_n = 1'b0;
        check("R9 irq", isa_irq, 0);
        ctl_int_n = 1'b1;

        // R1: address window sweep, two switch settings
        for (int s = 0; s < 2; s++) begin
            base_sw = (s == 0) ? 7'b1101101 : 7'b0010110;
            for (int i = 0; i < 128; i++) begin
                isa_addr = {i[6:0], 3'b101};
                #1 check("R1 brd_sel_n", brd_sel_n, (i[6:0] == base_sw) ? 0 : 1);
            end
        end
        base_sw = 7'b1101101;
        isa_addr = BASE;
        #1 check("R1 base 0x368", brd_sel_n, 0);

        // R2: controller data reads
        for (int v = 0; v < 4; v++) begin
            ctl_rdata = 8'h5A ^ (8'h33 * v[7:0]);
            bus_rd(BASE);
            check("R2 oe", o_oe, 1); check("R2 rd_n", o_rd, 0);
            check("R2 a0", o_a0, 0); check("R2 data", o_dout, ctl_rdata);
            check("R2 released", {isa_doe, ctl_rd_n}, 2'b01);
        end

        // R3: data and command writes
        bus_wr(BASE, 8'h11);
        check("R3 data wr_n", o_wr, 0); check("R3 data a0", o_a0, 0);
        check("R3 released", ctl_wr_n, 1);
        bus_wr(BASE + 1, 8'h22);
        check("R3 cmd wr_n", o_wr, 0); check("R3 cmd a0", o_a0, 1);

        // R4: status port sweep
        for (int k = 0; k < 128; k++) begin
            keys_n = k[3:0]; vbus_ok = k[4]; ctl_susp_pin = k[5]; ctl_int_n = k[6];
            bus_rd(BASE + 2);
            check("R4 oe", o_oe, 1);
            check("R4 status", o_dout, {k[6], k[5], k[4], 1'b0, k[3:0]});
        end
        ctl_int_n = 1'b0;

        // R5 R6 R7: control port sweep
        for (int v = 0; v < 256; v++) begin
            bus_wr(BASE + 3, v[7:0]);
            check("R5 leds", leds, v[3:0]);
            check("R6 susp", susp_force, v[6]);
            check("R7 irq", isa_irq, v[7]);
            check("R5 no ctl strobe", {o_wr, o_rd}, 2'b11);
        end

        // R7: level gating and re-arm
        bus_wr(BASE + 3, 8'h80);
        ctl_int_n = 1'b1; #1 check("R7 irq off when int high", isa_irq, 0);
        ctl_int_n = 1'b0; #1 check("R7 irq on", isa_irq, 1);
        bus_wr(BASE + 3, 8'h00); check("R7 disabled", isa_irq, 0);
        bus_wr(BASE + 3, 8'h80); check("R7 fresh edge", isa_irq, 1);

        // R8: ignored accesses
        bus_wr(BASE + 3, 8'hC5);
        for (int o = 4; o < 8; o++) begin
            bus_wr(BASE + o[9:0], 8'h3A);
            check("R8 wr no strobe", o_wr, 1);
            check("R8 wr state", {isa_irq, susp_force, leds}, {2'b11, 4'h5});
            bus_rd(BASE + o[9:0]);
            check("R8 rd no drive", {o_oe, o_rd}, 2'b01);
        end
        bus_wr(BASE + 2, 8'h3A);
        check("R8 wr status", {isa_irq, susp_force, leds, o_wr}, {2'b11, 4'h5, 1'b1});
        bus_rd(BASE + 1);
        check("R8 rd cmd", {o_oe, o_rd}, 2'b01);
        bus_rd(BASE + 3);
        check("R8 rd control", {o_oe, o_rd}, 2'b01);

        // R10: out of window, and collision
        bus_wr(10'h300 | 10'h3, 8'h0A);
        check("R10 outside", {isa_irq, susp_force, leds}, {2'b11, 4'h5});
        @(negedge clk); isa_addr = BASE; isa_ior_n = 1'b0; isa_iow_n = 1'b0;
        @(negedge clk);
        check("R10 collision", {isa_doe, ctl_rd_n, ctl_wr_n}, 3'b011);
        isa_ior_n = 1'b1; isa_iow_n = 1'b1;
        @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule